// File: doc/BRIEF.md
# Per-Cycle Wait State Inserter

This block stretches selected processor bus cycles by exactly one clock. A cycle counts as started when the sync term goes from false to true. The sync term is true for a memory request that is not a refresh, or for any I/O request. Two flops on the processor clock catch that rising edge and produce a one-clock start pulse.

Five enable bits, one per cycle class, decide whether that pulse becomes a wait request. The classes are opcode fetch, any memory cycle, on-board ROM cycle, input cycle and output cycle. The wait request is merged with an external active-low ready line into one active-low wait line. The same state also appears as an active-high acknowledge.

All bus strobe inputs are active high inside this block. Any inversion from the processor's pins is done outside it.

Top module: `wait_state_inserter`

## Requirements
- R1: While reset is held and ready_ni is high, wait_no is 1 and wait_ack_o is 0.
- R2: The sync term is (mreq_i AND NOT rfsh_i) OR iorq_i. The start pulse is high during the clock that follows the first rising edge of clk_i at which the sync term is sampled true after having been false.
- R3: A wait from the start pulse lasts exactly one clock, however long the cycle inputs are held.
- R4: A refresh cycle (mreq_i=1, rfsh_i=1, iorq_i=0) never produces a start pulse or a wait, even when all enable bits are 1.
- R5: Enable bit 0 (fetch class) inserts a wait when m1_i=1 and the sync term is true.
- R6: Enable bit 1 (memory class) inserts a wait on any memory cycle, read or write (mreq_i=1, rfsh_i=0).
- R7: Enable bit 2 (ROM class) inserts a wait on a memory cycle with rom_sel_i=1.
- R8: Enable bit 3 (input class) inserts a wait when iorq_i=1, rd_i=1 and m1_i=0.
- R9: Enable bit 4 (output class) inserts a wait when iorq_i=1 and wr_i=1.
- R10: A cycle whose matching classes all have their enable bit at 0 gets no wait. A cycle that matches several enabled classes still gets exactly one wait clock.
- R11: While ready_ni is 0, wait_no is 0, whatever the inserted wait is doing.
- R12: wait_ack_o is always the inverse of wait_no.
- R13: A new wait can only come after the sync term has been false for at least one sampled clock edge. Back-to-back cycles that keep the term true get only one wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mreq_i | input | 1 | Memory request, active high |
| iorq_i | input | 1 | I/O request, active high |
| rfsh_i | input | 1 | Refresh cycle, active high |
| m1_i | input | 1 | Opcode fetch indicator, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| rom_sel_i | input | 1 | On-board ROM addressed, active high |
| wait_en_i | input | 5 | Per-class enables: bit0 fetch, bit1 memory, bit2 ROM, bit3 input, bit4 output |
| ready_ni | input | 1 | External ready, active low holds wait |
| wait_no | output | 1 | Merged wait line to CPU, active low |
| wait_ack_o | output | 1 | Active-high copy of the wait state |

## Verification
Two things can land in the same clock: the inserted one-clock wait, and an external ready that is held low. The bench raises a fetch cycle with its class enabled while ready_ni is already low. It then releases ready_ni and checks that the wait line follows only ready_ni, with no extra clock left over from the insertion. A second overlap comes from cycles that match several enabled classes at once, such as a ROM fetch. These are checked across the full sweep of enable masks and must yield a single wait clock, never a longer one.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  localparam int unsigned N_CLASS = 5;

  typedef enum int unsigned {
    CLS_FETCH = 0,
    CLS_MEM   = 1,
    CLS_ROM   = 2,
    CLS_IN    = 3,
    CLS_OUT   = 4
  } cls_e;

  typedef struct packed {
    logic mreq;
    logic iorq;
    logic rfsh;
    logic m1;
    logic rd;
    logic wr;
    logic rom_sel;
  } bus_st_t;
endpackage

// File: rtl/wsi_class_decode.sv
module wsi_class_decode
  import wsi_pkg::*;
#(
  parameter int unsigned N = N_CLASS
) (
  input  bus_st_t        bus_i,
  output logic           sync_en_o,
  output logic [N-1:0]   hit_o
);
  logic mem_cyc;

  assign mem_cyc   = bus_i.mreq & ~bus_i.rfsh;
  assign sync_en_o = mem_cyc | bus_i.iorq;

  always_comb begin
    hit_o = '0;
    hit_o[CLS_FETCH] = bus_i.m1 & sync_en_o;
    hit_o[CLS_MEM]   = mem_cyc;
    hit_o[CLS_ROM]   = mem_cyc & bus_i.rom_sel;
    hit_o[CLS_IN]    = bus_i.iorq & bus_i.rd & ~bus_i.m1;
    hit_o[CLS_OUT]   = bus_i.iorq & bus_i.wr;
  end
endmodule

// File: rtl/wsi_cycle_start.sv
module wsi_cycle_start (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_en_i,
  output logic start_o
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= sync_en_i;
      stg2_q <= stg1_q;
    end
  end

  // high for the single clock after sync is first seen
  assign start_o = stg1_q & ~stg2_q;
endmodule

// File: rtl/wsi_wait_merge.sv
module wsi_wait_merge #(
  parameter int unsigned N = 5
) (
  input  logic         start_i,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] en_i,
  input  logic         ready_ni,
  output logic         wait_req_o,
  output logic         wait_no,
  output logic         wait_ack_o
);
  logic [N-1:0] cls_req;

  for (genvar k = 0; k < N; k++) begin : g_cls
    assign cls_req[k] = hit_i[k] & en_i[k];
  end

  assign wait_req_o = start_i & (|cls_req);
  assign wait_no    = ~(wait_req_o | ~ready_ni);
  assign wait_ack_o = ~wait_no;
endmodule

// File: rtl/wait_state_inserter.sv
module wait_state_inserter
  import wsi_pkg::*;
#(
  parameter int unsigned N = N_CLASS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mreq_i,
  input  logic         iorq_i,
  input  logic         rfsh_i,
  input  logic         m1_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic         rom_sel_i,
  input  logic [N-1:0] wait_en_i,
  input  logic         ready_ni,
  output logic         wait_no,
  output logic         wait_ack_o
);
  bus_st_t        bus;
  logic           sync_en;
  logic           start;
  logic           wait_req;
  logic [N-1:0]   hit;

  assign bus = '{mreq: mreq_i, iorq: iorq_i, rfsh: rfsh_i, m1: m1_i,
                 rd: rd_i, wr: wr_i, rom_sel: rom_sel_i};

  wsi_class_decode #(.N(N)) u_dec (
    .bus_i     (bus),
    .sync_en_o (sync_en),
    .hit_o     (hit)
  );

  wsi_cycle_start u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_en_i (sync_en),
    .start_o   (start)
  );

  wsi_wait_merge #(.N(N)) u_merge (
    .start_i    (start),
    .hit_i      (hit),
    .en_i       (wait_en_i),
    .ready_ni   (ready_ni),
    .wait_req_o (wait_req),
    .wait_no    (wait_no),
    .wait_ack_o (wait_ack_o)
  );
endmodule

// File: rtl/wait_state_inserter_chk.sv
module wait_state_inserter_chk #(
  parameter int unsigned N = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mreq_i,
  input logic         iorq_i,
  input logic         rfsh_i,
  input logic [N-1:0] wait_en_i,
  input logic         ready_ni,
  input logic         wait_no,
  input logic         wait_ack_o,
  input logic         start,
  input logic         wait_req
);
  logic se_port;
  assign se_port = (mreq_i & ~rfsh_i) | iorq_i;

  p_start_after_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> $past(se_port));

  p_single_clock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req |=> !wait_req);

  p_refresh_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_ni && mreq_i && rfsh_i && !iorq_i && $past(mreq_i && rfsh_i && !iorq_i))
      |-> wait_no);

  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_ni && wait_en_i == '0) |-> wait_no);

  p_ready_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_ni |-> !wait_no);

  p_ack_inverse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_ack_o == !wait_no);

  p_no_retrigger_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (se_port && $past(se_port)) |=> !start);
endmodule

bind wait_state_inserter wait_state_inserter_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mreq_i     (mreq_i),
  .iorq_i     (iorq_i),
  .rfsh_i     (rfsh_i),
  .wait_en_i  (wait_en_i),
  .ready_ni   (ready_ni),
  .wait_no    (wait_no),
  .wait_ack_o (wait_ack_o),
  .start      (start),
  .wait_req   (wait_req)
);

// File: tb/sim_wait_state_inserter.sv
`timescale 1ns/1ps
module sim_wait_state_inserter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mreq_i = 0, iorq_i = 0, rfsh_i = 0, m1_i = 0, rd_i = 0, wr_i = 0, rom_sel_i = 0;
  logic [4:0] wait_en_i = '0;
  logic       ready_ni = 1'b1;
  logic       wait_no, wait_ack_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  wait_state_inserter u0 (
    .clk_i, .rst_ni, .mreq_i, .iorq_i, .rfsh_i, .m1_i, .rd_i, .wr_i,
    .rom_sel_i, .wait_en_i, .ready_ni, .wait_no, .wait_ack_o
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    {mreq_i, iorq_i, rfsh_i, m1_i, rd_i, wr_i, rom_sel_i} = '0;
  endtask

  // kind: 0 fetch,1 mem rd,2 mem wr,3 rom rd,4 rom fetch,5 in,6 out,7 refresh
  task automatic drive(input int kind);
    idle();
    case (kind)
      0: begin mreq_i = 1; m1_i = 1; rd_i = 1; end
      1: begin mreq_i = 1; rd_i = 1; end
      2: begin mreq_i = 1; wr_i = 1; end
      3: begin mreq_i = 1; rd_i = 1; rom_sel_i = 1; end
      4: begin mreq_i = 1; rd_i = 1; m1_i = 1; rom_sel_i = 1; end
      5: begin iorq_i = 1; rd_i = 1; end
      6: begin iorq_i = 1; wr_i = 1; end
      default: begin mreq_i = 1; rfsh_i = 1; end
    endcase
  endtask

  function automatic logic [4:0] mask_of(input int kind);
    case (kind)
      0: return 5'b00011;
      1, 2: return 5'b00010;
      3: return 5'b00110;
      4: return 5'b00111;
      5: return 5'b01000;
      6: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic string tag_of(input int kind);
    case (kind)
      0: return "R5";
      1, 2: return "R6";
      3, 4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 wait_no in reset", wait_no, 1'b1);
    chk("R12 ack in reset", wait_ack_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // sweep all enable masks over every cycle kind
    for (int en = 0; en < 32; en++) begin
      for (int kind = 0; kind < 8; kind++) begin
        wait_en_i = en[4:0];
        idle();
        repeat (2) @(negedge clk_i);
        drive(kind);
        chk({tag_of(kind), " R2 no wait before edge"}, wait_no, 1'b1);
        @(negedge clk_i);
        chk({tag_of(kind), " R10 wait first clock"}, wait_no,
            !(|(mask_of(kind) & en[4:0])));
        chk("R12 ack", wait_ack_o, !wait_no);
        @(negedge clk_i);
        chk("R3 wait released", wait_no, 1'b1);
        @(negedge clk_i);
        chk("R3 still released", wait_no, 1'b1);
      end
    end

    // back-to-back cycles with sync held true
    wait_en_i = 5'b11111;
    idle(); repeat (2) @(negedge clk_i);
    drive(1);
    @(negedge clk_i); chk("R13 first cycle waits", wait_no, 1'b0);
    drive(6);
    @(negedge clk_i); chk("R13 io after mem no gap", wait_no, 1'b1);
    @(negedge clk_i); chk("R13 held", wait_no, 1'b1);
    idle();
    @(negedge clk_i); chk("R13 gap", wait_no, 1'b1);
    drive(6);
    @(negedge clk_i); chk("R13 after gap waits", wait_no, 1'b0);
    idle(); repeat (2) @(negedge clk_i);

    // ready low with coincident inserted wait
    wait_en_i = 5'b00001;
    ready_ni = 1'b0;
    @(negedge clk_i); chk("R11 ready low idle", wait_no, 1'b0);
    chk("R12 ack ready", wait_ack_o, 1'b1);
    drive(0);
    @(negedge clk_i); chk("R11 ready low + insert", wait_no, 1'b0);
    @(negedge clk_i); chk("R11 ready low after insert", wait_no, 1'b0);
    ready_ni = 1'b1;
    #1; chk("R11 ready released", wait_no, 1'b1);
    @(negedge clk_i); chk("R3 no leftover", wait_no, 1'b1);
    idle(); repeat (2) @(negedge clk_i);

    // long refresh with all classes enabled
    wait_en_i = 5'b11111;
    drive(7);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); chk("R4 refresh held", wait_no, 1'b1);
    end
    idle(); @(negedge clk_i);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule